// File: doc/BRIEF.md
# Trigger-Matched Hit Bucket Buffer

This block converts a free-running stream of detector hits into event frames read out on a trigger. Every hit word arrives tagged with the number of the beam crossing in which it was recorded. The block files the hit into a bucket selected by that crossing number. Together the buckets form a circular history of the most recent crossings, one bucket for each value of the local crossing counter.

When a Level-1 accept arrives, the block computes the crossing that lies a programmable number of crossings in the past. It emits that crossing's bucket as one frame on a ready/valid output: a header word, then the stored hits, then a trailer word. After the trailer is handed over, the bucket is released. It then collects hits again when the crossing counter comes round to it. Triggers that arrive during a readout wait in a short queue. Hits that arrive too late for their crossing are refused and counted.

Top module: `trig_bucket_buf`

## Requirements
- R1: While reset is held and straight after it, `out_valid`, `trig_lost` and `late_count` are 0 and `cur_bco` is 0.
- R2: `cur_bco` rises by one on every cycle with `bco_tick` high and wraps modulo 2^BCO_W (64 by default).
- R3: A hit is accepted when its age, `(cur_bco - hit_bco)` modulo 2^BCO_W, is smaller than `trig_delay`. An accepted hit is stored in bucket `hit_bco`, and the frame returns the stored hits in arrival order.
- R4: A frame consists of one header, then N hit words, then one trailer.
  - Header: `out_kind` = 2'b01. Bits [FILL_W-1:0] of `out_data` hold N and the next BCO_W bits hold the bucket number.
  - Hit words: `out_kind` = 2'b10, with `out_data` equal to the stored hit.
  - Trailer: `out_kind` = 2'b11, with bit 0 carrying the overflow flag.
  - `out_last` is high only on the trailer.
- R5: A trigger sampled at crossing `cur_bco` reads bucket `(cur_bco - trig_delay)` modulo 2^BCO_W. `trig_delay` must be nonzero.
- R6: A bucket holds at most MAX_HITS hits. Any further hit for that crossing is dropped, and the overflow flag in that frame's trailer is set to 1.
- R7: Once a trailer is accepted, its bucket is empty. A second trigger for the same crossing yields a frame with N = 0 and the overflow flag at 0.
- R8: When the counter enters a crossing, the bucket left over from the previous wrap of that crossing is discarded. Only hits from the new wrap appear in a later frame.
- R9: A hit whose age is `trig_delay` or more is neither stored nor framed. It raises `late_count` by one, and the count saturates.
- R10: Up to TQ_DEPTH (default 4) triggers wait in the queue. A trigger that arrives while the queue is full is discarded and raises `trig_lost` for one cycle.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_kind`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bco_tick | input | 1 | Crossing-clock enable, advances the crossing counter |
| trig_delay | input | BCO_W | Trigger latency in crossings |
| hit_valid | input | 1 | Hit word present |
| hit_bco | input | BCO_W | Crossing number of the hit |
| hit_data | input | HIT_W | Hit word |
| l1_accept | input | 1 | Level-1 accept, one cycle per trigger |
| out_valid | output | 1 | Frame word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_kind | output | 2 | Word type: 01 header, 10 hit, 11 trailer |
| out_data | output | HIT_W | Frame word payload |
| out_last | output | 1 | Marks the trailer |
| trig_lost | output | 1 | One-cycle pulse when a trigger is discarded |
| late_count | output | CNT_W | Saturating count of refused late hits |
| cur_bco | output | BCO_W | Local crossing counter |

## Verification
The assertions assume three things about the inputs:
- `trig_delay` is nonzero and stays constant while hits and triggers are in flight.
- A bucket is read out before the counter returns to its crossing.
- Hits never name the crossing that the counter is just entering.

The stimulus respects all three. It holds the delay at 3 for the whole run. It drains each frame within a few crossings of its trigger. It writes hits only for the current crossing, or for crossings older than the current one, when it probes the late-hit boundary.

// File: rtl/tbb_pkg.sv
package tbb_pkg;
   typedef enum logic [1:0] {
      KIND_NONE = 2'b00,
      KIND_HDR  = 2'b01,
      KIND_HIT  = 2'b10,
      KIND_TRL  = 2'b11
   } word_kind_e;
endpackage

// File: rtl/tbb_trig_fifo.sv
module tbb_trig_fifo #(
   parameter int W     = 6,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         head_valid,
   output logic [W-1:0] head_data,
   output logic         lost
);
   logic [W-1:0]     slots [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             full, do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (count != '0);

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         lost   <= 1'b0;
      end else begin
         lost <= push && full;
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (!do_push && do_pop) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slots[wr_ptr] <= push_data;
   end

   assign head_valid = (count != '0);
   assign head_data  = slots[rd_ptr];

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R10
   AST_LOST_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      lost |-> $past(count) == CNT_W'(DEPTH)); // R10
endmodule

// File: rtl/tbb_store.sv
module tbb_store #(
   parameter int BCO_W    = 6,
   parameter int HIT_W    = 16,
   parameter int MAX_HITS = 32,
   parameter int CNT_W    = 8,
   localparam int NB      = 1 << BCO_W,
   localparam int SLOT_W  = $clog2(MAX_HITS),
   localparam int FILL_W  = $clog2(MAX_HITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BCO_W-1:0]  cur_bco,
   input  logic [BCO_W-1:0]  trig_delay,
   input  logic              hit_valid,
   input  logic [BCO_W-1:0]  hit_bco,
   input  logic [HIT_W-1:0]  hit_data,
   input  logic              clr_vld,
   input  logic [BCO_W-1:0]  clr_idx,
   input  logic              free_vld,
   input  logic [BCO_W-1:0]  free_idx,
   input  logic [BCO_W-1:0]  look_idx,
   output logic [FILL_W-1:0] look_fill,
   output logic              look_ovf,
   input  logic [BCO_W-1:0]  rd_bucket,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [HIT_W-1:0]  rd_data,
   output logic [CNT_W-1:0]  late_count
);
   logic [HIT_W-1:0]  mem [NB * MAX_HITS];
   logic [FILL_W-1:0] fill [NB];
   logic [NB-1:0]     ovf;
   logic [NB-1:0]     vld;

   logic [BCO_W-1:0]  age;
   logic              is_late, wr_ok, room, wr_mem;
   logic [FILL_W-1:0] fill_eff;

   always_comb begin
      age      = cur_bco - hit_bco;
      is_late  = hit_valid && (age >= trig_delay);
      wr_ok    = hit_valid && !is_late;
      fill_eff = vld[hit_bco] ? fill[hit_bco] : '0;
      room     = (fill_eff < FILL_W'(MAX_HITS));
      wr_mem   = wr_ok && room;
   end

   always_ff @(posedge clk) begin
      if (wr_mem) mem[{hit_bco, fill_eff[SLOT_W-1:0]}] <= hit_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) fill[b] <= '0;
         ovf <= '0;
         vld <= '0;
      end else begin
         if (wr_ok) begin
            vld[hit_bco] <= 1'b1;
            if (room) begin
               fill[hit_bco] <= fill_eff + 1'b1;
               if (!vld[hit_bco]) ovf[hit_bco] <= 1'b0;
            end else begin
               ovf[hit_bco] <= 1'b1;
            end
         end
         if (clr_vld)  vld[clr_idx]  <= 1'b0;
         if (free_vld) vld[free_idx] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) late_count <= '0;
      else if (is_late && (late_count != '1)) late_count <= late_count + 1'b1;
   end

   assign look_fill = vld[look_idx] ? fill[look_idx] : '0;
   assign look_ovf  = vld[look_idx] && ovf[look_idx];
   assign rd_data   = mem[{rd_bucket, rd_slot}];

   AST_DELAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      trig_delay != '0); // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !room && !(clr_vld && clr_idx == hit_bco)) |=> ovf[$past(hit_bco)]); // R6
   AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      look_fill <= FILL_W'(MAX_HITS)); // R6
   AST_LATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |=> $stable(late_count)); // R9
endmodule

// File: rtl/tbb_reader.sv
module tbb_reader
   import tbb_pkg::*;
#(
   parameter int BCO_W    = 6,
   parameter int HIT_W    = 16,
   parameter int MAX_HITS = 32,
   localparam int SLOT_W  = $clog2(MAX_HITS),
   localparam int FILL_W  = $clog2(MAX_HITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_valid,
   input  logic [BCO_W-1:0]  q_bucket,
   output logic              q_pop,
   output logic [BCO_W-1:0]  look_idx,
   input  logic [FILL_W-1:0] look_fill,
   input  logic              look_ovf,
   output logic [BCO_W-1:0]  rd_bucket,
   output logic [SLOT_W-1:0] rd_slot,
   input  logic [HIT_W-1:0]  rd_data,
   output logic              free_vld,
   output logic [BCO_W-1:0]  free_idx,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [1:0]        out_kind,
   output logic [HIT_W-1:0]  out_data,
   output logic              out_last
);
   typedef enum logic [1:0] {S_IDLE, S_HDR, S_HIT, S_TRL} rd_state_e;

   rd_state_e         state;
   logic [BCO_W-1:0]  bkt_q;
   logic [FILL_W-1:0] n_q, slot_q;
   logic              ovf_q;
   word_kind_e        kind;

   assign q_pop     = (state == S_IDLE) && q_valid;
   assign look_idx  = (state == S_IDLE) ? q_bucket : bkt_q;
   assign rd_bucket = bkt_q;
   assign rd_slot   = slot_q[SLOT_W-1:0];
   assign free_vld  = (state == S_TRL) && out_ready;
   assign free_idx  = bkt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         bkt_q  <= '0;
         n_q    <= '0;
         slot_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (q_valid) begin
               bkt_q  <= q_bucket;
               n_q    <= look_fill;
               ovf_q  <= look_ovf;
               slot_q <= '0;
               state  <= S_HDR;
            end
            S_HDR: if (out_ready) state <= (n_q == '0) ? S_TRL : S_HIT;
            S_HIT: if (out_ready) begin
               if (slot_q == n_q - 1'b1) state <= S_TRL;
               else slot_q <= slot_q + 1'b1;
            end
            S_TRL: if (out_ready) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      kind     = KIND_NONE;
      out_data = '0;
      unique case (state)
         S_HDR: begin kind = KIND_HDR; out_data = HIT_W'({bkt_q, n_q}); end
         S_HIT: begin kind = KIND_HIT; out_data = rd_data; end
         S_TRL: begin kind = KIND_TRL; out_data = HIT_W'(ovf_q); end
         default: ;
      endcase
   end

   assign out_valid = (state != S_IDLE);
   assign out_kind  = kind;
   assign out_last  = (state == S_TRL);

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_data)
                                     && $stable(out_last))); // R11
   AST_HDR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (!out_valid || out_kind == KIND_HDR)); // R4
   AST_HDR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_kind == KIND_HDR) |=> (out_kind != KIND_HDR)); // R4
endmodule

// File: rtl/trig_bucket_buf.sv
module trig_bucket_buf #(
   parameter int BCO_W    = 6,
   parameter int HIT_W    = 16,
   parameter int MAX_HITS = 32,
   parameter int TQ_DEPTH = 4,
   parameter int CNT_W    = 8,
   localparam int SLOT_W  = $clog2(MAX_HITS),
   localparam int FILL_W  = $clog2(MAX_HITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bco_tick,
   input  logic [BCO_W-1:0] trig_delay,
   input  logic             hit_valid,
   input  logic [BCO_W-1:0] hit_bco,
   input  logic [HIT_W-1:0] hit_data,
   input  logic             l1_accept,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [1:0]       out_kind,
   output logic [HIT_W-1:0] out_data,
   output logic             out_last,
   output logic             trig_lost,
   output logic [CNT_W-1:0] late_count,
   output logic [BCO_W-1:0] cur_bco
);
   generate
      if ((MAX_HITS < 2) || ((MAX_HITS & (MAX_HITS - 1)) != 0)) begin : g_bad_hits
         $error("MAX_HITS must be a power of two, at least 2");
      end
      if (HIT_W < BCO_W + FILL_W) begin : g_bad_width
         $error("HIT_W too narrow for the header word");
      end
      if (TQ_DEPTH < 4) begin : g_bad_depth
         $error("TQ_DEPTH must be at least 4");
      end
   endgenerate

   logic [BCO_W-1:0]  next_bco, trig_bkt, q_bucket, look_idx, rd_bucket, free_idx;
   logic              q_valid, q_pop, free_vld, look_ovf;
   logic [FILL_W-1:0] look_fill;
   logic [SLOT_W-1:0] rd_slot;
   logic [HIT_W-1:0]  rd_data;

   assign next_bco = cur_bco + 1'b1;
   assign trig_bkt = cur_bco - trig_delay;

   always_ff @(posedge clk) begin
      if (!rst_n)        cur_bco <= '0;
      else if (bco_tick) cur_bco <= next_bco;
   end

   tbb_trig_fifo #(.W(BCO_W), .DEPTH(TQ_DEPTH)) u_tq (
      .clk, .rst_n,
      .push(l1_accept), .push_data(trig_bkt), .pop(q_pop),
      .head_valid(q_valid), .head_data(q_bucket), .lost(trig_lost)
   );

   tbb_store #(.BCO_W(BCO_W), .HIT_W(HIT_W), .MAX_HITS(MAX_HITS), .CNT_W(CNT_W)) u_store (
      .clk, .rst_n, .cur_bco, .trig_delay,
      .hit_valid, .hit_bco, .hit_data,
      .clr_vld(bco_tick), .clr_idx(next_bco),
      .free_vld, .free_idx,
      .look_idx, .look_fill, .look_ovf,
      .rd_bucket, .rd_slot, .rd_data,
      .late_count
   );

   tbb_reader #(.BCO_W(BCO_W), .HIT_W(HIT_W), .MAX_HITS(MAX_HITS)) u_rd (
      .clk, .rst_n,
      .q_valid, .q_bucket, .q_pop,
      .look_idx, .look_fill, .look_ovf,
      .rd_bucket, .rd_slot, .rd_data,
      .free_vld, .free_idx,
      .out_valid, .out_ready, .out_kind, .out_data, .out_last
   );

   AST_BCO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      bco_tick |=> cur_bco == $past(cur_bco) + 1'b1); // R2
   AST_BCO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bco_tick |=> $stable(cur_bco)); // R2
   AST_LATE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> late_count >= $past(late_count)); // R9
endmodule

// File: tb/tb_trig_bucket_buf.sv
module tb_trig_bucket_buf;
   localparam int BCO_W = 6, HIT_W = 16, MAX_HITS = 32, CNT_W = 8, DLY = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bco_tick = 0, hit_valid = 0, l1_accept = 0, out_ready = 1;
   logic [BCO_W-1:0] trig_delay = BCO_W'(DLY), hit_bco = '0;
   logic [HIT_W-1:0] hit_data = '0;
   logic out_valid, out_last, trig_lost;
   logic [1:0] out_kind;
   logic [HIT_W-1:0] out_data;
   logic [CNT_W-1:0] late_count;
   logic [BCO_W-1:0] cur_bco;

   trig_bucket_buf dut (.*);

   always #4 clk = ~clk;

   int checks = 0, errors = 0, cycles = 0, model_bco = 0;
   logic [1:0]       fr_kind [64];
   logic [HIT_W-1:0] fr_data [64];
   logic             fr_last [64];
   int               fr_len;

   // {hits written, expected count, expected overflow flag}
   localparam int VEC [6][3] = '{'{0, 0, 0}, '{1, 1, 0}, '{5, 5, 0},
                                 '{32, 32, 0}, '{33, 32, 1}, '{45, 32, 1}};

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      bco_tick = 1; @(negedge clk); bco_tick = 0;
      model_bco = (model_bco + 1) % 64;
   endtask

   function automatic logic [HIT_W-1:0] hword(input int b, input int i);
      return {2'b00, BCO_W'(b), 8'(i)};
   endfunction

   task automatic burst(input int b, input int n, input int base);
      for (int i = 0; i < n; i++) begin
         hit_valid = 1; hit_bco = BCO_W'(b); hit_data = hword(b, base + i);
         @(negedge clk);
      end
      hit_valid = 0;
   endtask

   task automatic trigger();
      l1_accept = 1; @(negedge clk); l1_accept = 0;
   endtask

   task automatic collect();
      int guard = 0;
      fr_len = 0;
      while (!out_valid && guard < 200) begin @(negedge clk); guard++; end
      while (out_valid && fr_len < 64) begin
         fr_kind[fr_len] = out_kind; fr_data[fr_len] = out_data; fr_last[fr_len] = out_last;
         fr_len++;
         if (fr_last[fr_len-1]) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic check_frame(input string tag, input int b, input int n, input int ovf,
                              input int base);
      chk(fr_len == n + 2, {tag, " frame length"}, fr_len, n + 2);
      if (fr_len != n + 2) return;
      chk(fr_kind[0] == 2'b01, {tag, " R4 header kind"}, fr_kind[0], 1);
      chk(fr_data[0][5:0] == 6'(n), {tag, " R4 header count"}, fr_data[0][5:0], n);
      chk(fr_data[0][11:6] == 6'(b), {tag, " R5 header bucket"}, fr_data[0][11:6], b);
      for (int i = 0; i < n; i++) begin
         chk(fr_kind[i+1] == 2'b10 && fr_data[i+1] == hword(b, base + i) && !fr_last[i+1],
             {tag, " R3 hit word"}, fr_data[i+1], hword(b, base + i));
      end
      chk(fr_kind[n+1] == 2'b11 && fr_last[n+1], {tag, " R4 trailer"}, fr_kind[n+1], 3);
      chk(fr_data[n+1][0] == 1'(ovf), {tag, " R6 overflow flag"}, fr_data[n+1][0], ovf);
   endtask

   initial begin
      int c, lost_seen, late0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!out_valid && !trig_lost, "R1 outputs idle in reset", out_valid, 0);
      chk(cur_bco == 0 && late_count == 0, "R1 counters zero", cur_bco, 0);
      rst_n = 1; @(negedge clk);
      chk(!out_valid && cur_bco == 0 && late_count == 0, "R1 after reset", out_valid, 0);

      // vector table: fill one crossing, trigger after DLY crossings, read it back
      foreach (VEC[v]) begin
         tick();
         c = model_bco;
         chk(cur_bco == BCO_W'(c), "R2 crossing counter", cur_bco, c);
         burst(c, VEC[v][0], v * 8);
         repeat (DLY) tick();
         trigger();
         collect();
         check_frame($sformatf("vec%0d", v), c, VEC[v][1], VEC[v][2], v * 8);
      end

      // R9: late hits refused, boundary age DLY-1 accepted
      tick(); c = model_bco;
      burst(c, 1, 0);
      repeat (DLY) tick();
      late0 = late_count;
      burst(c, 1, 50);
      burst((c + 64 - 10) % 64, 1, 51);
      @(negedge clk);
      chk(late_count == CNT_W'(late0 + 2), "R9 late hits counted", late_count, late0 + 2);
      burst((model_bco + 64 - (DLY - 1)) % 64, 1, 52);
      @(negedge clk);
      chk(late_count == CNT_W'(late0 + 2), "R9 age DLY-1 not late", late_count, late0 + 2);
      trigger(); collect();
      check_frame("late R9", c, 1, 0, 0);

      // R10, R11, R7: queue fill with stalled output, then drain
      tick(); c = model_bco;
      burst(c, 3, 20);
      repeat (DLY) tick();
      out_ready = 0;
      lost_seen = 0;
      l1_accept = 1;
      for (int k = 0; k < 6; k++) begin @(negedge clk); lost_seen += int'(trig_lost); end
      l1_accept = 0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); lost_seen += int'(trig_lost); end
      chk(lost_seen == 1, "R10 one trigger lost", lost_seen, 1);
      chk(out_valid && out_kind == 2'b01 && out_data[5:0] == 6'd3, "R11 header during stall",
          out_data[5:0], 3);
      repeat (4) @(negedge clk);
      chk(out_valid && out_kind == 2'b01 && out_data[5:0] == 6'd3, "R11 header held",
          out_data[5:0], 3);
      out_ready = 1;
      collect();
      check_frame("queue first", c, 3, 0, 20);
      for (int k = 0; k < 4; k++) begin
         collect();
         check_frame("R7 freed bucket", c, 0, 0, 0);
      end
      repeat (10) @(negedge clk);
      chk(!out_valid, "R10 no frame for lost trigger", out_valid, 0);

      // R8: stale bucket discarded on wrap; R2 wrap
      tick(); c = model_bco;
      burst(c, 4, 60);
      repeat (64) tick();
      chk(cur_bco == BCO_W'(c), "R2 wrap after 64 crossings", cur_bco, c);
      burst(c, 2, 100);
      repeat (DLY) tick();
      trigger(); collect();
      check_frame("R8 stale wrap", c, 2, 0, 100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule